// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power state a small microcontroller enters when its CPU executes a sleep instruction. At the moment the sleep strobe arrives it samples three configuration bits: a standby select, a sub-mode select and a direct-transition enable. From them it picks one of four outcomes:

- light sleep, where the CPU is halted and the clock keeps running;
- subsleep, where the main oscillator is off and the low-speed timers keep counting;
- standby, where everything is off and the I/O pins float;
- a direct transition that never leaves active mode.

Any external interrupt line or wakeup pin brings the block out of a low-power state into a settling phase. In that phase the oscillator runs again but the CPU stays halted for a programmable count. After the count the block returns to active mode and raises its ready output.

The outputs drive the clock generator, the CPU halt input, the reset and run-enable inputs of five peripherals, and a global output-disable for the port pads. Peripheral bit order in `blk_rst` and `blk_run` is as follows:

| Bit | Peripheral |
|---|---|
| 0 | general timer |
| 1 | serial interface |
| 2 | A/D converter |
| 3 | second timer |
| 4 | watchdog |

`blk_rst` covers bits 0 to 2 only.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After reset the block is active: `pm_state`=0, `cpu_halt`=0, `osc_en`=1, `blk_rst`=000, `blk_run`=11111, `io_hiz`=0, `active_ready`=1, `sel_err`=0.
- R2: A strobe in active mode with standby, sub and direct all 0 enters sleep (`pm_state`=1) on the next cycle. In sleep, `cpu_halt`=1, `osc_en`=1, no peripheral is in reset and all five run.
- R3: A strobe with standby 0, sub 1 and direct 0 enters subsleep (`pm_state`=2). In subsleep, `osc_en`=0, `cpu_halt`=1, `blk_rst`=111 with bits 0 to 2 of `blk_run` low, and the second timer and watchdog (`blk_run` bits 3 and 4) keep running.
- R4: A strobe with standby 1 and direct 0 enters standby (`pm_state`=3) whatever the sub bit is. In standby, `osc_en`=0, `cpu_halt`=1, `blk_rst`=111, `blk_run`=00000 and `io_hiz`=1.
- R5: A strobe with direct 1 and sub 1 clear keeps the block active (`pm_state`=0, no halt), whatever the standby bit is.
- R6: A strobe with direct 1 and sub 1 enters sleep and sets `sel_err`. `sel_err` keeps its value until the next accepted strobe, which clears it if that strobe's bits form a valid combination.
- R7: Every accepted strobe with sub 1 drives `blk_rst`=111, with bits 0 to 2 of `blk_run` low, for the first cycle after the strobe. In sleep, this pulse is the only time the peripherals are held in reset.
- R8: In sleep, subsleep or standby, a high level on any interrupt line or wakeup pin moves the block to settling (`pm_state`=4). With settle count S, it stays there for S+1 cycles and then becomes active with `active_ready`=1.
- R9: Wake requests take effect in every low-power state, including standby with the oscillator stopped. Each interrupt line and each wakeup pin can wake the block on its own.
- R10: A strobe is ignored in any state other than active. A wake request is ignored in active and in settling, and does not restart the settle count.
- R11: While settling, `cpu_halt`=1 and `active_ready`=0. `osc_en`=1, all peripherals run out of reset and `io_hiz`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| cfg_stby | input | 1 | Standby select bit |
| cfg_sub | input | 1 | Sub-mode select bit |
| cfg_direct | input | 1 | Direct-transition enable bit |
| irq_ext | input | IRQ_N | External interrupt request lines |
| wake_pin | input | WKP_N | Wakeup pin requests |
| settle_cnt | input | SETTLE_W | Oscillator settling count S |
| pm_state | output | 3 | 0 active, 1 sleep, 2 subsleep, 3 standby, 4 settling |
| cpu_halt | output | 1 | CPU halt request |
| osc_en | output | 1 | Main oscillator enable |
| blk_rst | output | 3 | Resets: general timer, serial, A/D |
| blk_run | output | 5 | Run enables, bit order per the peripheral table |
| io_hiz | output | 1 | Force all port outputs to high impedance |
| active_ready | output | 1 | Active mode reached and CPU released |
| sel_err | output | 1 | Invalid direct-plus-sub selection seen |

## Verification
The bench targets the two standby encodings, the direct-with-sub error case and its one-cycle peripheral reset pulse, and settle counts of 0 and 3.

- A decoder that let the sub bit override standby would land in subsleep and leave the I/O driven.
- A decoder that honoured direct with sub set would stay active with no error flag.
- A missing or stretched reset pulse shows as wrong `blk_rst` values in the two cycles after the error strobe.
- A settle counter that is off by one or restarts on a second wake request moves the cycle in which `active_ready` rises.
- Strobes accepted while halted would change `pm_state`.

// File: rtl/pm_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: the state encoding below is visible at the pm_state port and is
// relied on by software and the bench.
package pm_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE   = 3'd0,
        PM_SLEEP    = 3'd1,
        PM_SUBSLEEP = 3'd2,
        PM_STANDBY  = 3'd3,
        PM_SETTLE   = 3'd4
    } pm_mode_e;

    // Peripheral slots; the first PM_RST_N of them have a reset input.
    localparam int PM_BLK_N  = 5;
    localparam int PM_RST_N  = 3;
    localparam int BLK_TMR2  = 3;
    localparam int BLK_WDT   = 4;

    // Result of decoding the three selection bits at a sleep strobe.
    typedef struct packed {
        pm_mode_e target;
        logic     sel_err;
        logic     clr_blk;
    } pm_decode_t;

endpackage

// File: rtl/pm_decode.sv
// Selection decoder: maps the standby, sub-mode and direct bits sampled at a
// sleep strobe to a target state, an error flag and a peripheral-clear request.
// Assumes: purely combinational; the caller qualifies it with the strobe.
module pm_decode
    import pm_pkg::*;
(
    input  logic       stby,
    input  logic       sub,
    input  logic       direct,
    output pm_decode_t dec
);

    // Priority: direct first, then standby, then sub.
    always_comb begin
        dec.sel_err = 1'b0;
        dec.clr_blk = sub;
        if (direct) begin
            if (sub) begin
                dec.target  = PM_SLEEP;
                dec.sel_err = 1'b1;
            end else begin
                dec.target  = PM_ACTIVE;
            end
        end else if (stby) begin
            dec.target = PM_STANDBY;
        end else if (sub) begin
            dec.target = PM_SUBSLEEP;
        end else begin
            dec.target = PM_SLEEP;
        end
    end

endmodule

// File: rtl/pm_settle.sv
// Settling counter: loaded with the programmed count on a wake request,
// counts down while enabled, reports done when it has reached zero.
// Assumes: load and en are never both high in the same cycle.
module pm_settle #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Load on wake, otherwise count down to zero while settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero means the settling window is over.
    always_comb done = (cnt_q == '0);

endmodule

// File: rtl/pm_gate.sv
// Output gating: turns the current power state into CPU, oscillator,
// peripheral and pad controls.
// Assumes: clr_pulse is a one-cycle request that adds reset on top of the
// state-based reset.
module pm_gate
    import pm_pkg::*;
(
    input  pm_mode_e              mode,
    input  logic                  clr_pulse,
    output logic                  cpu_halt,
    output logic                  osc_en,
    output logic [PM_RST_N-1:0]   blk_rst,
    output logic [PM_BLK_N-1:0]   blk_run,
    output logic                  io_hiz,
    output logic                  active_ready
);

    logic osc_off;
    logic hold_rst;

    // Decode the state into its gating classes.
    always_comb begin
        osc_off      = (mode == PM_SUBSLEEP) || (mode == PM_STANDBY);
        hold_rst     = osc_off;
        cpu_halt     = (mode != PM_ACTIVE);
        active_ready = (mode == PM_ACTIVE);
        osc_en       = !osc_off;
        io_hiz       = (mode == PM_STANDBY);
    end

    // Resettable peripherals: held in reset when the oscillator is off or pulsed.
    for (genvar i = 0; i < PM_RST_N; i++) begin : g_rst_blk
        assign blk_rst[i] = hold_rst | clr_pulse;
        assign blk_run[i] = ~blk_rst[i];
    end

    // Low-speed peripherals keep running everywhere except standby.
    always_comb begin
        blk_run[BLK_TMR2] = (mode != PM_STANDBY);
        blk_run[BLK_WDT]  = (mode != PM_STANDBY);
    end

endmodule

// File: rtl/pm_mode_ctrl.sv
// Low-power mode sequencer top: accepts sleep strobes in active mode,
// enters the decoded low-power state, wakes on any interrupt or wakeup pin,
// and holds the CPU through a programmable settling window.
// Assumes: sleep_req is a one-cycle strobe; wake inputs are synchronous.
module pm_mode_ctrl
    import pm_pkg::*;
#(
    parameter int IRQ_N    = 2,
    parameter int WKP_N    = 6,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                cfg_stby,
    input  logic                cfg_sub,
    input  logic                cfg_direct,
    input  logic [IRQ_N-1:0]    irq_ext,
    input  logic [WKP_N-1:0]    wake_pin,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic [2:0]          pm_state,
    output logic                cpu_halt,
    output logic                osc_en,
    output logic [PM_RST_N-1:0] blk_rst,
    output logic [PM_BLK_N-1:0] blk_run,
    output logic                io_hiz,
    output logic                active_ready,
    output logic                sel_err
);

    pm_mode_e   state_q;
    pm_decode_t dec;
    logic       accept;
    logic       wake_any;
    logic       low_pwr;
    logic       settle_done;
    logic       clr_pulse_q;
    logic       sel_err_q;

    pm_decode u_dec (
        .stby   (cfg_stby),
        .sub    (cfg_sub),
        .direct (cfg_direct),
        .dec    (dec)
    );

    // Qualify strobes and wake requests with the current state.
    always_comb begin
        low_pwr  = (state_q == PM_SLEEP) || (state_q == PM_SUBSLEEP) ||
                   (state_q == PM_STANDBY);
        accept   = sleep_req && (state_q == PM_ACTIVE);
        wake_any = (|irq_ext) || (|wake_pin);
    end

    pm_settle #(.W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (low_pwr && wake_any),
        .load_val (settle_cnt),
        .en       (state_q == PM_SETTLE),
        .done     (settle_done)
    );

    // Power-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_ACTIVE;
        end else if (accept) begin
            state_q <= dec.target;
        end else if (low_pwr && wake_any) begin
            state_q <= PM_SETTLE;
        end else if (state_q == PM_SETTLE && settle_done) begin
            state_q <= PM_ACTIVE;
        end
    end

    // Error flag and one-cycle peripheral clear, both set by accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_err_q   <= 1'b0;
            clr_pulse_q <= 1'b0;
        end else begin
            clr_pulse_q <= accept && dec.clr_blk;
            if (accept) begin
                sel_err_q <= dec.sel_err;
            end
        end
    end

    pm_gate u_gate (
        .mode         (state_q),
        .clr_pulse    (clr_pulse_q),
        .cpu_halt     (cpu_halt),
        .osc_en       (osc_en),
        .blk_rst      (blk_rst),
        .blk_run      (blk_run),
        .io_hiz       (io_hiz),
        .active_ready (active_ready)
    );

    // Export state and flag.
    always_comb begin
        pm_state = state_q;
        sel_err  = sel_err_q;
    end

endmodule

// File: rtl/pm_mode_ctrl_chk.sv
// Property checker for the low-power mode sequencer, attached by bind.
// Assumes: it only observes the top-level ports.
module pm_mode_ctrl_chk #(
    parameter int IRQ_N = 2,
    parameter int WKP_N = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic             cfg_sub,
    input logic             cfg_direct,
    input logic [IRQ_N-1:0] irq_ext,
    input logic [WKP_N-1:0] wake_pin,
    input logic [2:0]       pm_state,
    input logic             osc_en,
    input logic [2:0]       blk_rst,
    input logic             io_hiz,
    input logic             active_ready,
    input logic             sel_err
);

    logic wake_any;
    assign wake_any = (|irq_ext) || (|wake_pin);

    // R4
    hiz_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hiz |-> !osc_en);

    // R3
    subsleep_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd2) |-> (blk_rst == 3'b111 && !osc_en));

    // R5
    direct_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd0 && sleep_req && cfg_direct && !cfg_sub) |=> (pm_state == 3'd0));

    // R6
    bad_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd0 && sleep_req && cfg_direct && cfg_sub) |=> (sel_err && pm_state == 3'd1));

    // R8
    ready_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_ready) |-> ($past(pm_state) == 3'd4));

    // R10
    lowpwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pm_state == 3'd1 || pm_state == 3'd2 || pm_state == 3'd3) && !wake_any) |=> $stable(pm_state));

endmodule

bind pm_mode_ctrl pm_mode_ctrl_chk #(.IRQ_N(IRQ_N), .WKP_N(WKP_N)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .cfg_sub      (cfg_sub),
    .cfg_direct   (cfg_direct),
    .irq_ext      (irq_ext),
    .wake_pin     (wake_pin),
    .pm_state     (pm_state),
    .osc_en       (osc_en),
    .blk_rst      (blk_rst),
    .io_hiz       (io_hiz),
    .active_ready (active_ready),
    .sel_err      (sel_err)
);

// File: tb/pm_mode_ctrl_tb_top.sv
module pm_mode_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_N      = 2;
    localparam int WKP_N      = 6;
    localparam int SETTLE_W   = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sleep_req = 1'b0;
    logic                cfg_stby = 1'b0;
    logic                cfg_sub = 1'b0;
    logic                cfg_direct = 1'b0;
    logic [IRQ_N-1:0]    irq_ext = '0;
    logic [WKP_N-1:0]    wake_pin = '0;
    logic [SETTLE_W-1:0] settle_cnt = 8'd3;
    logic [2:0]          pm_state;
    logic                cpu_halt, osc_en, io_hiz, active_ready, sel_err;
    logic [2:0]          blk_rst;
    logic [4:0]          blk_run;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    pm_mode_ctrl #(.IRQ_N(IRQ_N), .WKP_N(WKP_N), .SETTLE_W(SETTLE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cfg_stby(cfg_stby), .cfg_sub(cfg_sub), .cfg_direct(cfg_direct),
        .irq_ext(irq_ext), .wake_pin(wake_pin), .settle_cnt(settle_cnt),
        .pm_state(pm_state), .cpu_halt(cpu_halt), .osc_en(osc_en),
        .blk_rst(blk_rst), .blk_run(blk_run), .io_hiz(io_hiz),
        .active_ready(active_ready), .sel_err(sel_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected output vector for a state, built from the requirements.
    function automatic logic [15:0] ev(int m, logic err, logic pulse);
        logic       halt, osc, hiz, rdy, slow;
        logic [2:0] rst;
        halt = (m != 0);
        osc  = !(m == 2 || m == 3);
        rst  = (m == 2 || m == 3 || pulse) ? 3'b111 : 3'b000;
        slow = (m != 3);
        hiz  = (m == 3);
        rdy  = (m == 0);
        return {m[2:0], halt, osc, rst, slow, slow, ~rst, hiz, rdy, err};
    endfunction

    task automatic expect_at(int at, logic [15:0] v, string req);
        item_t it;
        it.at = at; it.exp = v; it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: pops due items and compares against the outputs.
    always @(negedge clk) begin
        logic [15:0] act;
        act = {pm_state, cpu_halt, osc_en, blk_rst, blk_run, io_hiz, active_ready, sel_err};
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            checks++;
            if (sb_q[0].at != cyc || act !== sb_q[0].exp) begin
                fails++;
                $display("FAIL %s at cycle %0d: actual=%h expected=%h",
                         sb_q[0].req, cyc, act, sb_q[0].exp);
            end
            void'(sb_q.pop_front());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    // Strobe with the given bits; expects the outcome on the next cycle.
    task automatic strobe(logic s, logic u, logic d, int m, logic err, logic pulse, string req);
        step();
        cfg_stby = s; cfg_sub = u; cfg_direct = d; sleep_req = 1'b1;
        expect_at(cyc + 1, ev(m, err, pulse), req);
        step();
        sleep_req = 1'b0; cfg_stby = 1'b0; cfg_sub = 1'b0; cfg_direct = 1'b0;
    endtask

    // Wake via interrupt (kind 0) or pin (kind 1), with settle count s.
    task automatic wake(int kind, int idx, int s, logic err, string req);
        int c;
        step();
        settle_cnt = s[SETTLE_W-1:0];
        if (kind == 0) irq_ext[idx] = 1'b1; else wake_pin[idx] = 1'b1;
        c = cyc;
        expect_at(c + 1, ev(4, err, 0), req);
        expect_at(c + s + 1, ev(4, err, 0), req);
        expect_at(c + s + 2, ev(0, err, 0), req);
        step();
        irq_ext = '0; wake_pin = '0;
        while (cyc < c + s + 3) step();
    endtask

    initial begin
        int c;
        repeat (3) step();
        rst_n = 1'b1;
        expect_at(cyc, ev(0, 0, 0), "R1");
        step();
        expect_at(cyc, ev(0, 0, 0), "R1");

        // Sleep, ignored strobe, wake by interrupt.
        strobe(0, 0, 0, 1, 0, 0, "R2");
        strobe(0, 1, 0, 1, 0, 0, "R10 strobe ignored in sleep");
        wake(0, 0, 3, 0, "R8");

        // Wake ignored in active.
        step();
        wake_pin[2] = 1'b1;
        expect_at(cyc + 1, ev(0, 0, 0), "R10 wake ignored in active");
        step();
        wake_pin = '0;
        step();

        // Subsleep, wake by pin.
        strobe(0, 1, 0, 2, 0, 1, "R3");
        expect_at(cyc + 1, ev(2, 0, 0), "R3");
        step();
        wake(1, 5, 3, 0, "R9 wake from subsleep by pin");

        // Standby, both sub values, settle count zero.
        strobe(1, 0, 0, 3, 0, 0, "R4");
        wake(0, 1, 0, 0, "R9 wake from standby");
        strobe(1, 1, 0, 3, 0, 1, "R4 sub ignored");
        wake(1, 0, 3, 0, "R11");

        // Direct transitions.
        strobe(0, 0, 1, 0, 0, 0, "R5");
        strobe(1, 0, 1, 0, 0, 0, "R5 standby ignored");

        // Invalid combination: error flag and reset pulse.
        strobe(0, 1, 1, 1, 1, 1, "R6 R7 pulse");
        expect_at(cyc + 1, ev(1, 1, 0), "R7 pulse ends");
        step();
        wake(0, 0, 3, 1, "R6 flag held");
        strobe(0, 0, 1, 0, 0, 0, "R6 flag cleared");

        // Second wake during settling does not restart the count.
        strobe(0, 0, 0, 1, 0, 0, "R2");
        step();
        settle_cnt = 8'd3;
        irq_ext[0] = 1'b1;
        c = cyc;
        step();
        irq_ext = '0;
        step();
        wake_pin[1] = 1'b1;
        expect_at(c + 4, ev(4, 0, 0), "R10 wake ignored in settle");
        expect_at(c + 5, ev(0, 0, 0), "R10 wake ignored in settle");
        step();
        wake_pin = '0;
        while (cyc < c + 7) step();

        while (sb_q.size() > 0) step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule